// File: doc/BRIEF.md
# Quad SPI frame sequencer

This block is the serial engine of a flash-oriented SPI master. One pulse on `start` runs a single frame whose shape is taken from configuration inputs: the frame length in bytes, the number of leading command bytes, the number of idle clocks between the command part and the data part, the lane mode, the dual/quad width select, the SCLK divider and the SCLK rest level. The block drives SCLK, an active-low chip select and four DQ lanes, each with its own output enable, so that the pad ring can build the bidirectional pins.

Bytes to send come from a valid/ready byte stream. Bytes that come back are pushed out on a byte stream with a one-cycle valid and no backpressure. The leading command bytes are only sent, and whatever the lanes carry during them is dropped. Every byte after them is returned. The lane mode chooses which part of the frame runs on one lane and which part runs on two or four. A surrounding controller reads `ready` to know when the engine can take the next frame, and uses `tx_done` and `rx_done` as completion events.

Top module: `qspi_frame_seq`

## Requirements
- R1: After reset, `cs_n` and `ready` are 1, `sclk` is 0, `dq_oe` is 0, and `rx_valid`, `tx_done` and `rx_done` are 0.
- R2: In lane mode 00, each byte takes eight SCLK cycles. The byte is driven MSB first on DQ0 with `dq_oe` = 0001, and the returned bits are sampled from DQ1.
- R3: Byte k of a frame (counting from 0) is returned on the receive stream only when k is not less than the command count. A command count equal to the frame length returns nothing, and a command count of 0 returns every byte.
- R4: In lane mode 11, every byte uses the multi-lane width: two bits per clock on DQ1..DQ0 (`quad_sel` = 0) or four bits per clock on DQ3..DQ0 (`quad_sel` = 1), high bits first. Command bytes drive with `dq_oe` = 0011 or 1111. Returned bytes leave all lanes released (`dq_oe` = 0000) and are sampled from the same lanes.
- R5: In lane mode 10, byte 0 goes out on DQ0 alone when it is a command byte. Every later byte follows the multi-lane rules of R4.
- R6: In lane mode 01, all command bytes are single-lane on DQ0. The data part only receives on the multi-lane width and never drives a lane, so no multi-lane write can occur in this mode.
- R7: `quad_sel` has no effect in lane mode 00.
- R8: When the frame has a data part (command count below the length) and the idle count is nonzero, exactly that many SCLK cycles with every lane released are placed after the last command byte and before the first returned byte. A frame with no data part has no idle cycles.
- R9: One SCLK half-period lasts N system clocks, where N is `clk_div` for values 1 to 15 and 16 when `clk_div` is 0.
- R10: Outside a frame, SCLK rests at the level of `clk_idle_hi`. Every bit cycle is a low half followed by a high half, and input bits are sampled on the rising edge.
- R11: From the cycle after an accepted `start` until the frame ends, `cs_n` and `ready` are both 0. `cs_n` goes low at least one half-period before the first SCLK edge, and all lanes are released while `cs_n` is high.
- R12: The frame length is {`len_hi`,`len_lo`}. A `start` with a length of zero is ignored.
- R13: A byte is taken from the transmit stream only for bytes that drive lanes (command bytes, and every byte in mode 00). While such a byte is not yet available, SCLK does not move.
- R14: `tx_done` is a one-cycle pulse when the last byte of the frame finishes. `rx_done` is a one-cycle pulse in the cycle after the last returned byte is pushed, and it occurs only in frames that return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (taken while ready) |
| len_lo | input | 16 | Frame length, low half |
| len_hi | input | 16 | Frame length, high half |
| cmd_len | input | 9 | Leading bytes whose receive data is dropped |
| idle_len | input | 4 | Idle SCLK cycles between command and data parts |
| lane_mode | input | 2 | 00 single, 01 command+address single, 10 command single, 11 all multi-lane |
| quad_sel | input | 1 | Multi-lane width: 0 two lanes, 1 four lanes |
| clk_div | input | 4 | SCLK half-period in system clocks (0 means 16) |
| clk_idle_hi | input | 1 | SCLK rest level |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes the byte this cycle if valid |
| rx_data | output | 8 | Returned byte |
| rx_valid | output | 1 | Returned byte valid (one cycle) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |
| ready | output | 1 | Idle and able to take a frame |
| tx_done | output | 1 | Last byte of frame finished |
| rx_done | output | 1 | Last returned byte pushed |

## Verification
The bench runs a simple device model that records lanes and enables at each rising SCLK edge and feeds a known nibble pattern back. It compares every edge with a frame model built from the requirements. The cases it targets are the boundaries of the command count. A count of 0 must return every byte, and a count equal to the length must return nothing and insert no idle cycles. An off-by-one at this boundary shows up as an extra or missing returned byte, or as idle clocks placed in the wrong spot. The bench also covers the mode 10 and mode 01 splits, where a design that mixed up phases would drive lanes during a read or put a later command byte on the wrong width. A stalled transmit stream must freeze SCLK, and a divider of 0 must give the slowest clock rather than the fastest.

// File: rtl/qspi_frame_seq.sv
`timescale 1ns/1ps
module qspi_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] len_lo,
  input  logic [15:0] len_hi,
  input  logic [8:0]  cmd_len,
  input  logic [3:0]  idle_len,
  input  logic [1:0]  lane_mode,
  input  logic        quad_sel,
  input  logic [3:0]  clk_div,
  input  logic        clk_idle_hi,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        sclk,
  output logic        cs_n,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i,
  output logic        ready,
  output logic        tx_done,
  output logic        rx_done
);
  localparam int LW = 32;
  localparam int CW = 9;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_NEXT, S_SHIFT, S_GAP, S_TRAIL} st_t;
  st_t st;

  logic [LW-1:0] tot, idx;
  logic [CW-1:0] cmd;
  logic [3:0]    idl, div, hc, gc, bc;
  logic [1:0]    mode, lw;
  logic          quad, pol, half, gap_done, drive, rx_en, lastp;
  logic [7:0]    sh, rxs;

  logic          tick, at_end, is_cmd, go_gap, need_tx, single, byte_last;
  logic [1:0]    nlw;
  logic [LW-1:0] cmd_x;

  assign cmd_x     = {{(LW-CW){1'b0}}, cmd};
  assign tick      = (hc == 4'd0);
  assign at_end    = (idx == tot);
  assign is_cmd    = (idx < cmd_x);
  assign go_gap    = !at_end && (idx == cmd_x) && (idl != 4'd0) && !gap_done;
  assign need_tx   = is_cmd || (mode == 2'b00);
  assign single    = (mode == 2'b00) || (mode == 2'b01 && is_cmd) ||
                     (mode == 2'b10 && idx == '0 && is_cmd);
  assign nlw       = single ? 2'd0 : (quad ? 2'd2 : 2'd1);
  assign byte_last = (idx + 1'b1 == tot);

  assign ready    = (st == S_IDLE);
  assign cs_n     = (st == S_IDLE);
  assign tx_ready = (st == S_NEXT) && !at_end && !go_gap && need_tx;
  assign sclk     = (st == S_SHIFT || st == S_GAP) ? half : pol;
  assign tx_done  = lastp;

  always_comb begin
    dq_oe = 4'b0000;
    dq_o  = 4'b0000;
    if (st == S_SHIFT && drive) begin
      case (lw)
        2'd0:    begin dq_oe = 4'b0001; dq_o = {3'b000, sh[7]};   end
        2'd1:    begin dq_oe = 4'b0011; dq_o = {2'b00, sh[7:6]};  end
        default: begin dq_oe = 4'b1111; dq_o = sh[7:4];           end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tot <= '0; idx <= '0; cmd <= '0;
      idl <= '0; div <= '0; hc <= '0; gc <= '0; bc <= '0;
      mode <= '0; lw <= '0; quad <= 1'b0; pol <= 1'b0; half <= 1'b0;
      gap_done <= 1'b0; drive <= 1'b0; rx_en <= 1'b0; lastp <= 1'b0;
      sh <= '0; rxs <= '0; rx_data <= '0; rx_valid <= 1'b0; rx_done <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      lastp    <= 1'b0;
      rx_done  <= lastp && rx_valid;
      if (st inside {S_LEAD, S_SHIFT, S_GAP, S_TRAIL})
        hc <= tick ? div - 4'd1 : hc - 4'd1;
      case (st)
        S_IDLE: begin
          pol <= clk_idle_hi;
          if (start && {len_hi, len_lo} != '0) begin
            tot      <= {len_hi, len_lo};
            cmd      <= cmd_len;
            idl      <= idle_len;
            mode     <= lane_mode;
            quad     <= quad_sel;
            div      <= clk_div;
            idx      <= '0;
            gap_done <= 1'b0;
            hc       <= clk_div - 4'd1;
            st       <= S_LEAD;
          end
        end
        S_LEAD: if (tick) st <= S_NEXT;
        S_NEXT: begin
          if (at_end) begin
            hc <= div - 4'd1;
            st <= S_TRAIL;
          end else if (go_gap) begin
            gc   <= idl;
            half <= 1'b0;
            hc   <= div - 4'd1;
            st   <= S_GAP;
          end else if (!need_tx || tx_valid) begin
            sh    <= need_tx ? tx_data : 8'h00;
            lw    <= nlw;
            drive <= need_tx;
            rx_en <= !is_cmd;
            bc    <= (nlw == 2'd0) ? 4'd8 : (nlw == 2'd1) ? 4'd4 : 4'd2;
            half  <= 1'b0;
            hc    <= div - 4'd1;
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick) begin
          if (!half) begin
            half <= 1'b1;
            case (lw)
              2'd0:    rxs <= {rxs[6:0], dq_i[1]};
              2'd1:    rxs <= {rxs[5:0], dq_i[1:0]};
              default: rxs <= {rxs[3:0], dq_i};
            endcase
          end else begin
            half <= 1'b0;
            bc   <= bc - 4'd1;
            case (lw)
              2'd0:    sh <= {sh[6:0], 1'b0};
              2'd1:    sh <= {sh[5:0], 2'b00};
              default: sh <= {sh[3:0], 4'b0000};
            endcase
            if (bc == 4'd1) begin
              idx      <= idx + 1'b1;
              rx_valid <= rx_en;
              rx_data  <= rxs;
              lastp    <= byte_last;
              st       <= S_NEXT;
            end
          end
        end
        S_GAP: if (tick) begin
          if (!half) half <= 1'b1;
          else begin
            half <= 1'b0;
            gc   <= gc - 4'd1;
            if (gc == 4'd1) begin
              gap_done <= 1'b1;
              st       <= S_NEXT;
            end
          end
        end
        S_TRAIL: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_frame_seq_chk.sv
`timescale 1ns/1ps
module qspi_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       clk_idle_hi,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] dq_oe,
  input logic       tx_done,
  input logic       rx_done
);
  assert_cs_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start));

  assert_lanes_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> dq_oe == 4'b0000);

  assert_oe_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(rst_n)) |-> sclk == $past(clk_idle_hi));

  assert_stall_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> $stable(sclk));

  assert_tx_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_rx_done_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rx_valid));

  assert_rx_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(cs_n));
endmodule

bind qspi_frame_seq qspi_frame_seq_chk u_chk (.*);

// File: tb/tb_qspi_frame_seq.sv
`timescale 1ns/1ps
module tb_qspi_frame_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] len_lo = '0, len_hi = '0;
  logic [8:0] cmd_len = '0;
  logic [3:0] idle_len = '0, clk_div = 4'd1, dq_i = '0;
  logic [1:0] lane_mode = '0;
  logic quad_sel = 1'b0, clk_idle_hi = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready, rx_valid, sclk, cs_n, ready, tx_done, rx_done;
  logic [7:0] rx_data;
  logic [3:0] dq_o, dq_oe;

  always #4 clk = ~clk;

  qspi_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_lo(len_lo), .len_hi(len_hi),
    .cmd_len(cmd_len), .idle_len(idle_len), .lane_mode(lane_mode), .quad_sel(quad_sel),
    .clk_div(clk_div), .clk_idle_hi(clk_idle_hi), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .ready(ready), .tx_done(tx_done), .rx_done(rx_done));

  int n_chk = 0, n_fail = 0, seed = 0;
  logic [7:0] txb [0:63];
  int txk = 0; bit tx_en = 1'b1;
  logic [3:0] rec_o [0:255];
  logic [3:0] rec_oe [0:255];
  time rec_t [0:255];
  int ne = 0;
  logic [7:0] rxgot [0:63];
  int nrx = 0, ntxd = 0, nrxd = 0, bad_ready = 0, cyc = 0, last_rx_cyc = 0, rxd_cyc = 0;
  time cs_fall_t = 0;
  bit prev_cs = 1'b1, finished = 1'b0;

  function automatic logic [3:0] pat(input int e);
    return 4'((e * 7 + seed) & 15);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model: record lanes at each rising SCLK inside a frame, feed next input nibble
  initial begin
    forever begin
      @(posedge sclk); #1;
      if (!cs_n && ne < 256) begin
        rec_o[ne] = dq_o; rec_oe[ne] = dq_oe; rec_t[ne] = $time;
        ne++;
        dq_i = pat(ne);
      end
    end
  end

  // transmit stream feeder
  initial begin
    bit take;
    tx_valid = 1'b0; tx_data = 8'h00;
    forever begin
      @(negedge clk); take = tx_valid && tx_ready;
      @(posedge clk); #1;
      if (take) txk++;
      tx_data = txb[txk % 64];
      tx_valid = tx_en;
    end
  end

  // output sampler
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rx_valid) begin
        if (nrx < 64) rxgot[nrx] = rx_data;
        nrx++; last_rx_cyc = cyc;
      end
      if (tx_done) ntxd++;
      if (rx_done) begin nrxd++; rxd_cyc = cyc; end
      if (!cs_n && ready) bad_ready++;
      if (!cs_n && prev_cs) cs_fall_t = $time;
      prev_cs = cs_n;
    end
  end

  task automatic run_frame(input string req, input int tot, input int cmd, input int idle,
                           input int mode, input int quad, input int div, input int pol,
                           input int sd, input int stall);
    int e, k, r, errs, fo, fe, rxerr, to, hn, w, cy;
    logic [7:0] exp_rx [0:63];
    logic [7:0] tb, acc;
    logic [3:0] oe_x, o_x;
    bit isc, sgl, drv;
    seed = sd;
    for (int i = 0; i < 64; i++) txb[i] = 8'(sd * 13 + i * 37 + 5);
    ne = 0; nrx = 0; ntxd = 0; nrxd = 0; bad_ready = 0; txk = 0;
    tx_data = txb[0]; dq_i = pat(0);
    tx_en = (stall == 0); tx_valid = tx_en;
    @(negedge clk);
    len_lo = 16'(tot); len_hi = 16'h0; cmd_len = 9'(cmd); idle_len = 4'(idle);
    lane_mode = 2'(mode); quad_sel = 1'(quad); clk_div = 4'(div); clk_idle_hi = 1'(pol);
    @(negedge clk); @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(!cs_n && !ready, "R11", "busy after start", {cs_n, ready}, 0);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      check(ne == 0 && !cs_n, "R13", "SCLK edges while tx stalled", ne, 0);
      tx_en = 1'b1;
    end
    to = 0;
    while (!ready && to < 20000) begin @(negedge clk); to++; end
    check(ready && cs_n, "R11", "frame end releases cs_n", {ready, cs_n}, 3);
    check(bad_ready == 0, "R11", "ready high during frame", bad_ready, 0);
    check(sclk == 1'(pol), "R10", "SCLK rest level", sclk, pol);
    hn = (div == 0) ? 16 : div;
    if (ne > 0)
      check(rec_t[0] - cs_fall_t >= hn * 8, "R11", "cs lead time ns",
            rec_t[0] - cs_fall_t, hn * 8);
    // expected frame
    e = 0; k = 0; r = 0; errs = 0; fo = -1; fe = 0;
    for (int b = 0; b < tot; b++) begin
      if (b == cmd && cmd < tot && idle > 0)
        for (int i = 0; i < idle; i++) begin
          if (e < 256 && rec_oe[e] != 4'b0000) begin errs++; if (fo < 0) begin fo = rec_oe[e]; fe = 0; end end
          e++;
        end
      isc = (b < cmd);
      sgl = (mode == 0) || (mode == 1 && isc) || (mode == 2 && b == 0 && isc);
      w = sgl ? 1 : (quad != 0 ? 4 : 2);
      drv = isc || mode == 0;
      tb = drv ? txb[k % 64] : 8'h00;
      if (drv) k++;
      acc = 8'h00;
      cy = 8 / w;
      for (int c = 0; c < cy; c++) begin
        oe_x = !drv ? 4'b0000 : (w == 1 ? 4'b0001 : (w == 2 ? 4'b0011 : 4'b1111));
        if (w == 1)      o_x = {3'b000, tb[7 - c]};
        else if (w == 2) o_x = 4'((tb >> (6 - 2 * c)) & 8'h03);
        else             o_x = 4'((tb >> (4 - 4 * c)) & 8'h0F);
        if (!drv) o_x = 4'b0000;
        if (e < 256 && (rec_oe[e] != oe_x || (rec_o[e] & oe_x) != o_x)) begin
          errs++;
          if (fo < 0) begin fo = {rec_oe[e], rec_o[e]}; fe = {oe_x, o_x}; end
        end
        if (w == 1)      acc = {acc[6:0], pat(e)[1]};
        else if (w == 2) acc = {acc[5:0], pat(e)[1:0]};
        else             acc = {acc[3:0], pat(e)};
        e++;
      end
      if (!isc) begin
        if (r < 64) exp_rx[r] = acc;
        r++;
      end
    end
    check(ne == e, req, "SCLK edge count", ne, e);
    check(errs == 0, req, "lane enable/value per edge {oe,o}", fo, fe);
    check(nrx == r, "R3", "returned byte count", nrx, r);
    rxerr = 0; fo = 0; fe = 0;
    for (int i = 0; i < r && i < nrx && i < 64; i++)
      if (rxgot[i] != exp_rx[i]) begin
        if (rxerr == 0) begin fo = rxgot[i]; fe = exp_rx[i]; end
        rxerr++;
      end
    check(rxerr == 0, req, "returned byte value", fo, fe);
    check(txk == k, "R13", "transmit bytes taken", txk, k);
    check(ntxd == 1, "R14", "tx_done pulses", ntxd, 1);
    check(nrxd == ((r > 0) ? 1 : 0), "R14", "rx_done pulses", nrxd, (r > 0) ? 1 : 0);
    if (r > 0) check(rxd_cyc == last_rx_cyc + 1, "R14", "rx_done cycle after last byte",
                     rxd_cyc, last_rx_cyc + 1);
  endtask

  task automatic t_reset_r1;
    check(cs_n && ready && !sclk && dq_oe == 4'b0000 && !rx_valid && !tx_done && !rx_done,
          "R1", "reset state {cs_n,ready,sclk,oe}", {cs_n, ready, sclk, dq_oe}, 6'b110000);
  endtask

  task automatic t_zero_len_r12;
    bit bad = 1'b0;
    @(negedge clk); len_lo = 16'h0; len_hi = 16'h0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (!ready || !cs_n) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R12", "zero-length start ignored", bad, 0);
  endtask

  task automatic t_period_r9(input int div, input int mode, input int quad);
    int hn;
    run_frame("R9", 1, 0, 0, mode, quad, div, 0, 11, 0);
    hn = (div == 0) ? 16 : div;
    check(ne >= 2 && rec_t[1] - rec_t[0] == 2 * hn * 8, "R9", "SCLK period ns",
          rec_t[1] - rec_t[0], 2 * hn * 8);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    run_frame("R2", 4, 1, 0, 0, 0, 1, 0, 1, 0);
    run_frame("R3", 3, 3, 0, 0, 0, 1, 0, 2, 0);
    run_frame("R3", 3, 0, 0, 0, 0, 1, 0, 3, 0);
    run_frame("R7", 2, 1, 0, 0, 1, 1, 0, 4, 0);
    run_frame("R4", 4, 2, 0, 3, 0, 1, 0, 5, 0);
    run_frame("R8", 5, 3, 2, 3, 1, 1, 0, 6, 0);
    run_frame("R5", 4, 2, 4, 2, 1, 2, 0, 7, 0);
    run_frame("R6", 6, 4, 3, 1, 1, 1, 1, 8, 0);
    run_frame("R8", 3, 3, 5, 3, 0, 1, 0, 9, 0);
    run_frame("R8", 2, 0, 1, 3, 0, 1, 1, 10, 0);
    t_period_r9(3, 0, 0);
    t_period_r9(0, 3, 1);
    run_frame("R13", 2, 1, 0, 0, 0, 1, 0, 12, 30);
    t_zero_len_r12();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule